// File: doc/BRIEF.md
# Hardware Cursor Register Bank

This block holds every setting that a display pipe's cursor logic needs: on/off, pixel format, 2x magnification, inverse-transparent clamping, screen position, hotspot offset, size, two colours for the two-colour formats, and a 40-bit byte address of the cursor surface in memory. Software programs it through a write-only port: a strobe, a 4-bit word offset and a 32-bit data word.

Every write lands in a pending copy. The settings that the display logic sees (the active copy) follow the pending copy only while the update lock is clear. Software sets the lock, rewrites as many settings as it needs, then clears the lock. All changed settings then reach the active outputs together, one cycle later, so a frame never sees half an update. The surface address is split across two registers. The upper byte is held in a staging register and only joins the pending address when the lower word is written. As a result, the address never changes with only one half updated.

Top module: `cursor_regbank`

## Requirements
- R1: After reset the lock is clear, every pending and active setting is zero, and the outputs show format 0 (monochrome), so cur_color1 = 0, cur_color2 = 0xFFFFFF, cur_width = cur_height = 1 and cur_base_addr = 0.
- R2: A write to offset 0 loads the update lock from wr_data[0]: 1 sets the lock and 0 clears it.
- R3: While the lock is set, every active output keeps its value, whatever is written to the other offsets.
- R4: In each cycle in which the lock is clear, the whole pending set is copied to the active set at the next edge. A write made while the lock is clear therefore shows at the outputs two edges after the strobe. After an unlock, all pending changes appear together in the same cycle.
- R5: Offset 1 holds the control fields: bit 0 enable, bits 2:1 format (0 monochrome, 1 colour with 1-bit AND mask, 2 pre-multiplied alpha, 3 straight alpha), bit 3 2x magnify and bit 4 inverse-transparent clamp.
- R6: Offset 2 holds the position (X in bits 12:0, Y in bits 28:16). Offset 3 holds the hotspot (X in bits 5:0, Y in bits 21:16).
- R7: Offset 4 holds the size as pixel count minus one (width in bits 7:0, height in bits 23:16). cur_width and cur_height give the count, so a stored 255 reads as 256.
- R8: Offsets 5 and 6 hold colour 1 and colour 2 as 24-bit RGB in bits 23:0. When the active format is monochrome, cur_color1 is forced to 0 and cur_color2 to 0xFFFFFF. Otherwise both follow their registers.
- R9: Offset 7 writes address bits 39:32 (from wr_data[7:0]) into a staging register only, and leaves the pending address unchanged. A write to offset 8 loads pending bits 31:12 from wr_data[31:12] and, in the same edge, bits 39:32 from the staging register.
- R10: cur_base_addr bits 11:0 are always zero, whatever wr_data[11:0] held in the offset 8 write.
- R11: Writes to offsets 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register word offset |
| wr_data | input | 32 | Write data |
| cur_enable | output | 1 | Cursor on |
| cur_mode | output | 2 | Pixel format code |
| cur_magnify | output | 1 | 2x magnification |
| cur_clamp | output | 1 | Inverse-transparent clamp |
| cur_x | output | 13 | Position X |
| cur_y | output | 13 | Position Y |
| cur_hot_x | output | 6 | Hotspot X |
| cur_hot_y | output | 6 | Hotspot Y |
| cur_width | output | 9 | Width in pixels |
| cur_height | output | 9 | Height in pixels |
| cur_color1 | output | 24 | Colour 1 after monochrome forcing |
| cur_color2 | output | 24 | Colour 2 after monochrome forcing |
| cur_base_addr | output | 40 | Surface byte address, 4 KB aligned |

## Verification
The pending-to-active copy and a new pending write can fall on the same edge. This happens when software clears the lock and, in the very next cycle, writes a register again. The active set must then take the value held before that write, and the newer value must follow one cycle later. The bench provokes this directly: it unlocks and at once rewrites the control register. It also does so at random, mixing lock and unlock writes among random writes to every offset. A behavioural model compares all outputs on every clock, so an early or merged copy shows up as a mismatch in that cycle.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    parameter int DW     = 32;
    parameter int AW     = 4;
    parameter int POS_W  = 13;
    parameter int HOT_W  = 6;
    parameter int SZ_W   = 8;
    parameter int COL_W  = 24;
    parameter int ADDR_W = 40;
    parameter int PAGE_W = 12;

    localparam int HI_W = ADDR_W - DW;
    localparam int LO_W = DW - PAGE_W;
    localparam int Y_LSB = 16;

    localparam logic [AW-1:0] OFF_LOCK = AW'(0);
    localparam logic [AW-1:0] OFF_CTRL = AW'(1);
    localparam logic [AW-1:0] OFF_POS  = AW'(2);
    localparam logic [AW-1:0] OFF_HOT  = AW'(3);
    localparam logic [AW-1:0] OFF_SIZE = AW'(4);
    localparam logic [AW-1:0] OFF_COL1 = AW'(5);
    localparam logic [AW-1:0] OFF_COL2 = AW'(6);
    localparam logic [AW-1:0] OFF_AHI  = AW'(7);
    localparam logic [AW-1:0] OFF_ALO  = AW'(8);

    typedef enum logic [1:0] {
        FMT_MONO     = 2'd0,
        FMT_AND1     = 2'd1,
        FMT_PREMUL   = 2'd2,
        FMT_STRAIGHT = 2'd3
    } cur_fmt_e;

    typedef struct packed {
        logic             enable;
        cur_fmt_e         fmt;
        logic             magnify;
        logic             clamp;
        logic [POS_W-1:0] x;
        logic [POS_W-1:0] y;
        logic [HOT_W-1:0] hx;
        logic [HOT_W-1:0] hy;
        logic [SZ_W-1:0]  w_m1;
        logic [SZ_W-1:0]  h_m1;
        logic [COL_W-1:0] col1;
        logic [COL_W-1:0] col2;
        logic [HI_W-1:0]  addr_hi;
        logic [LO_W-1:0]  addr_lo;
    } cur_cfg_t;
endpackage

// File: rtl/cursor_pend.sv
module cursor_pend
    import cursor_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output cur_cfg_t      pend,
    output logic          lock
);
    typedef struct packed {
        cur_cfg_t        cfg;
        logic [HI_W-1:0] hi_stage;
        logic            lock;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                OFF_LOCK: st_d.lock = wr_data[0];
                OFF_CTRL: begin
                    st_d.cfg.enable  = wr_data[0];
                    st_d.cfg.fmt     = cur_fmt_e'(wr_data[2:1]);
                    st_d.cfg.magnify = wr_data[3];
                    st_d.cfg.clamp   = wr_data[4];
                end
                OFF_POS: begin
                    st_d.cfg.x = wr_data[POS_W-1:0];
                    st_d.cfg.y = wr_data[Y_LSB+POS_W-1:Y_LSB];
                end
                OFF_HOT: begin
                    st_d.cfg.hx = wr_data[HOT_W-1:0];
                    st_d.cfg.hy = wr_data[Y_LSB+HOT_W-1:Y_LSB];
                end
                OFF_SIZE: begin
                    st_d.cfg.w_m1 = wr_data[SZ_W-1:0];
                    st_d.cfg.h_m1 = wr_data[Y_LSB+SZ_W-1:Y_LSB];
                end
                OFF_COL1: st_d.cfg.col1 = wr_data[COL_W-1:0];
                OFF_COL2: st_d.cfg.col2 = wr_data[COL_W-1:0];
                OFF_AHI:  st_d.hi_stage = wr_data[HI_W-1:0];
                OFF_ALO: begin
                    st_d.cfg.addr_hi = st_q.hi_stage;
                    st_d.cfg.addr_lo = wr_data[DW-1:PAGE_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.cfg;
    assign lock = st_q.lock;

    // R9
    addr_only_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == OFF_ALO) |=>
            ($stable(pend.addr_hi) && $stable(pend.addr_lo)));

    // R2
    lock_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFF_LOCK) |=> (lock == $past(wr_data[0])));
endmodule

// File: rtl/cursor_commit.sv
module cursor_commit
    import cursor_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lock,
    input  cur_cfg_t pend,
    output cur_cfg_t act
);
    cur_cfg_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (!lock) act_d = pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign act = act_q;

    // R3
    hold_while_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(act));

    // R4
    copy_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> (act == $past(pend)));
endmodule

// File: rtl/cursor_regbank.sv
module cursor_regbank
    import cursor_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    output logic                cur_enable,
    output logic [1:0]          cur_mode,
    output logic                cur_magnify,
    output logic                cur_clamp,
    output logic [POS_W-1:0]    cur_x,
    output logic [POS_W-1:0]    cur_y,
    output logic [HOT_W-1:0]    cur_hot_x,
    output logic [HOT_W-1:0]    cur_hot_y,
    output logic [SZ_W:0]       cur_width,
    output logic [SZ_W:0]       cur_height,
    output logic [COL_W-1:0]    cur_color1,
    output logic [COL_W-1:0]    cur_color2,
    output logic [ADDR_W-1:0]   cur_base_addr
);
    cur_cfg_t pend, act;
    logic     lock;

    cursor_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pend    (pend),
        .lock    (lock)
    );

    cursor_commit u_commit (
        .clk   (clk),
        .rst_n (rst_n),
        .lock  (lock),
        .pend  (pend),
        .act   (act)
    );

    logic mono;
    assign mono = (act.fmt == FMT_MONO);

    assign cur_enable    = act.enable;
    assign cur_mode      = act.fmt;
    assign cur_magnify   = act.magnify;
    assign cur_clamp     = act.clamp;
    assign cur_x         = act.x;
    assign cur_y         = act.y;
    assign cur_hot_x     = act.hx;
    assign cur_hot_y     = act.hy;
    assign cur_width     = (SZ_W+1)'(act.w_m1) + (SZ_W+1)'(1);
    assign cur_height    = (SZ_W+1)'(act.h_m1) + (SZ_W+1)'(1);
    assign cur_color1    = mono ? '0 : act.col1;
    assign cur_color2    = mono ? '1 : act.col2;
    assign cur_base_addr = {act.addr_hi, act.addr_lo, {PAGE_W{1'b0}}};
endmodule

// File: tb/cursor_regbank_tb.sv
`timescale 1ns/1ps
module cursor_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        cur_enable, cur_magnify, cur_clamp;
    logic [1:0]  cur_mode;
    logic [12:0] cur_x, cur_y;
    logic [5:0]  cur_hot_x, cur_hot_y;
    logic [8:0]  cur_width, cur_height;
    logic [23:0] cur_color1, cur_color2;
    logic [39:0] cur_base_addr;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cursor_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cur_enable(cur_enable), .cur_mode(cur_mode), .cur_magnify(cur_magnify),
        .cur_clamp(cur_clamp), .cur_x(cur_x), .cur_y(cur_y), .cur_hot_x(cur_hot_x),
        .cur_hot_y(cur_hot_y), .cur_width(cur_width), .cur_height(cur_height),
        .cur_color1(cur_color1), .cur_color2(cur_color2), .cur_base_addr(cur_base_addr)
    );

    // Behavioural model: field index 0 en,1 fmt,2 mag,3 clamp,4 x,5 y,6 hx,7 hy,
    // 8 w-1,9 h-1,10 col1,11 col2,12 addr hi,13 addr 31:12
    int p [14];
    int a [14];
    int m_lock, m_hi;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 14; i++) begin p[i] = 0; a[i] = 0; end
            m_lock = 0; m_hi = 0;
        end else begin
            if (m_lock == 0) for (int i = 0; i < 14; i++) a[i] = p[i];
            if (wr_en) begin
                case (wr_addr)
                    0: m_lock = wr_data[0];
                    1: begin p[0] = wr_data[0]; p[1] = wr_data[2:1]; p[2] = wr_data[3]; p[3] = wr_data[4]; end
                    2: begin p[4] = wr_data[12:0]; p[5] = wr_data[28:16]; end
                    3: begin p[6] = wr_data[5:0]; p[7] = wr_data[21:16]; end
                    4: begin p[8] = wr_data[7:0]; p[9] = wr_data[23:16]; end
                    5: p[10] = wr_data[23:0];
                    6: p[11] = wr_data[23:0];
                    7: m_hi = wr_data[7:0];
                    8: begin p[12] = m_hi; p[13] = wr_data[31:12]; end
                    default: ;
                endcase
            end
        end
    end

    task automatic cmp(input string req, input string what, input longint act_v, input longint exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    task automatic cmp_all();
        longint addr_e;
        addr_e = {longint'(a[12]) << 32} | (longint'(a[13]) << 12);
        cmp("R5", "cur_enable", cur_enable, a[0]);
        cmp("R5", "cur_mode", cur_mode, a[1]);
        cmp("R5", "cur_magnify", cur_magnify, a[2]);
        cmp("R5", "cur_clamp", cur_clamp, a[3]);
        cmp("R6", "cur_x", cur_x, a[4]);
        cmp("R6", "cur_y", cur_y, a[5]);
        cmp("R6", "cur_hot_x", cur_hot_x, a[6]);
        cmp("R6", "cur_hot_y", cur_hot_y, a[7]);
        cmp("R7", "cur_width", cur_width, a[8] + 1);
        cmp("R7", "cur_height", cur_height, a[9] + 1);
        cmp("R8", "cur_color1", cur_color1, (a[1] == 0) ? 0 : a[10]);
        cmp("R8", "cur_color2", cur_color2, (a[1] == 0) ? 'hFFFFFF : a[11]);
        cmp("R9", "cur_base_addr", cur_base_addr, addr_e);
        cmp("R10", "cur_base_addr low bits", cur_base_addr[11:0], 0);
    endtask

    always @(negedge clk) if (cmp_on && !done) cmp_all();

    task automatic wr(input logic [3:0] ad, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = ad; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1..: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [12:0] x_keep;
        idle(3);
        // R1 reset state
        cmp("R1", "cur_color2 reset", cur_color2, 'hFFFFFF);
        cmp("R1", "cur_width reset", cur_width, 1);
        cmp("R1", "cur_base_addr reset", cur_base_addr, 0);
        cmp("R1", "cur_enable reset", cur_enable, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        idle(1);

        // R5 unlocked write reaches outputs two edges later
        wr(4'd1, 32'h0000_0005);
        cmp("R4", "cur_mode one edge after write", cur_mode, 0);
        idle(1);
        cmp("R5", "cur_mode premul", cur_mode, 2);
        cmp("R5", "cur_enable", cur_enable, 1);

        // R2 R3 lock holds, R4 unlock releases all at once
        wr(4'd0, 32'h1);
        wr(4'd2, 32'h00C8_0064);
        wr(4'd3, 32'h0007_0009);
        idle(3);
        cmp("R3", "cur_x held", cur_x, 0);
        cmp("R3", "cur_hot_y held", cur_hot_y, 0);
        wr(4'd0, 32'h0);
        cmp("R4", "cur_x before copy", cur_x, 0);
        idle(1);
        cmp("R4", "cur_x after unlock", cur_x, 100);
        cmp("R4", "cur_y after unlock", cur_y, 200);
        cmp("R6", "cur_hot_y", cur_hot_y, 7);

        // copy and new pending write on the same edge
        wr(4'd0, 32'h1);
        wr(4'd1, 32'h0000_0017);
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h0000_0002);
        cmp("R4", "cur_mode copy edge", cur_mode, 3);
        cmp("R5", "cur_clamp copy edge", cur_clamp, 1);
        idle(1);
        cmp("R5", "cur_mode after rewrite", cur_mode, 1);
        cmp("R5", "cur_clamp after rewrite", cur_clamp, 0);

        // R9 high half alone does nothing; R10 low bits forced zero
        wr(4'd7, 32'h0000_00AB);
        idle(2);
        cmp("R9", "addr after high only", cur_base_addr, 0);
        wr(4'd8, 32'h1234_5FFF);
        idle(1);
        cmp("R9", "addr complete", cur_base_addr, 40'hAB_1234_5000);
        cmp("R10", "addr low bits", cur_base_addr[11:0], 0);

        // R8 monochrome forcing
        wr(4'd5, 32'h0012_3456);
        wr(4'd6, 32'h0065_4321);
        wr(4'd1, 32'h0000_0001);
        idle(1);
        cmp("R8", "mono colour1", cur_color1, 0);
        cmp("R8", "mono colour2", cur_color2, 'hFFFFFF);
        wr(4'd1, 32'h0000_0003);
        idle(1);
        cmp("R8", "and-mask colour1", cur_color1, 'h123456);
        cmp("R8", "and-mask colour2", cur_color2, 'h654321);

        // R7 size extremes
        wr(4'd4, 32'h0000_00FF);
        idle(1);
        cmp("R7", "width max", cur_width, 256);
        cmp("R7", "height min", cur_height, 1);

        // R11 unmapped offsets
        x_keep = cur_x;
        for (int o = 9; o < 16; o++) wr(4'(o), 32'hFFFF_FFFF);
        idle(2);
        cmp("R11", "cur_x after unmapped", cur_x, x_keep);
        cmp("R11", "cur_color1 after unmapped", cur_color1, 'h123456);
        cmp("R11", "cur_base_addr after unmapped", cur_base_addr, 40'hAB_1234_5000);

        // random mix, model compared on every clock
        for (int k = 0; k < 2000; k++) begin
            if ($urandom_range(0, 3) == 0) idle(1);
            else wr(4'($urandom_range(0, 15)), $urandom);
        end
        wr(4'd0, 32'h0);
        idle(3);
        finish_run();
    end
endmodule